// File: doc/BRIEF.md
# Sample FIFO with half-full interrupt

This block buffers tagged conversion results between a conversion engine and a byte-wide host port. Each 16-bit entry holds a channel tag in bits 3:0 and a 12-bit sample in bits 15:4. The FIFO holds 1024 entries. It raises an interrupt when it becomes half full, so the host can drain a fixed block of 512 samples on each interrupt.

The host sees a small register window addressed by `bus_addr`:

| Address | Read | Write |
|---|---|---|
| 0 | – | enable (any nonzero value enables, zero disables) |
| 1 | – | interrupt clear |
| 2 | data, low byte | – |
| 3 | data, high byte (completes the pop) | – |
| 4 | status | flush |

The status byte is {5'b0, overflow, half, empty}. A typical shutdown is an interrupt clear, then a flush, then a disable.

Top module: `conv_fifo`

## Requirements
- R1: After reset the FIFO is disabled and empty, the status byte at address 4 reads 0x01, and `irq` is low.
- R2: Entries leave in the order they were pushed. A read at address 2 returns bits 7:0 of the head entry, which include the channel tag in bits 3:0. The next read at address 3 returns bits 15:8 of that same entry, and that high-byte read removes the entry.
- R3: The status byte reads {5'b0, overflow, half, empty}. Bit 0 is set when no entry is held, and bit 1 is set when 512 or more entries are held.
- R4: `irq` rises within two cycles after the occupancy reaches 512, and it stays low while the occupancy is 511.
- R5: A write to address 1 drops `irq`. After that, `irq` stays low even as more entries arrive, until the occupancy falls below 512 and then reaches 512 again.
- R6: A push that arrives while 1024 entries are held is dropped. It sets the overflow bit (status bit 2), and that bit stays set while entries are popped.
- R7: A write to address 4 empties the FIFO and clears the overflow bit and `irq`.
- R8: While the FIFO is disabled, pushes are ignored, but entries already stored are kept and can still be read.
- R9: A read at address 2 while the FIFO is empty returns the low byte of the last popped entry and moves no pointer.
- R10: The writes interrupt clear, flush and disable, applied in that order, leave the FIFO empty with `irq` low, and later pushes are ignored.
- R11: A push and a pop in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Conversion result present this cycle |
| push_data | input | 16 | Result: tag in 3:0, sample in 15:4 |
| bus_addr | input | 3 | Host register address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational on `bus_addr`) |
| irq | output | 1 | Half-full interrupt request |

## Verification
The hardest states to reach are the full FIFO and the re-arming of the interrupt after a clear. The bench gets there by streaming pushes every cycle to exactly 511, 512, 513 and 1024 entries. Around each of those points it makes single pops and pushes, so the interrupt has to fall below the threshold and cross it again, and a push is dropped against a full FIFO.

// File: rtl/conv_fifo.sv
module conv_fifo #(
  parameter int DEPTH = 1024,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH/2);
  localparam logic [2:0] A_EN = 3'd0, A_CLR = 3'd1, A_LO = 3'd2, A_HI = 3'd3, A_STAT = 3'd4;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic [DW-1:0] hold;
  logic          en, ovf, pend, half_q;

  wire empty    = (count == '0);
  wire full     = (count == CNT_FULL);
  wire half     = (count >= CNT_HALF);
  wire flush_wr = bus_wr && bus_addr == A_STAT;
  wire clr_wr   = bus_wr && bus_addr == A_CLR;
  wire en_wr    = bus_wr && bus_addr == A_EN;
  wire lo_rd    = bus_rd && bus_addr == A_LO;
  wire hi_rd    = bus_rd && bus_addr == A_HI;
  wire do_push  = en && push_valid && !full;
  wire drop     = en && push_valid && full;
  wire do_pop   = hi_rd && pend;

  always_ff @(posedge clk)
    if (do_push && !flush_wr) mem[wr_ptr] <= push_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count <= '0;
      ovf <= 1'b0;
      pend <= 1'b0;
      hold <= '0;
      half_q <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (en_wr) en <= |bus_wdata;
      if (flush_wr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count <= '0;
        ovf <= 1'b0;
        pend <= 1'b0;
        half_q <= 1'b0;
        irq <= 1'b0;
      end else begin
        if (do_push) wr_ptr <= wr_ptr + 1'b1;
        if (do_pop) rd_ptr <= rd_ptr + 1'b1;
        count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        if (drop) ovf <= 1'b1;
        if (lo_rd && !empty) begin
          hold <= mem[rd_ptr];
          pend <= 1'b1;
        end else if (hi_rd) begin
          pend <= 1'b0;
        end
        half_q <= half;
        if (clr_wr) irq <= 1'b0;
        else if (half && !half_q) irq <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_LO:    bus_rdata = empty ? hold[7:0] : mem[rd_ptr][7:0];
      A_HI:    bus_rdata = hold[15:8];
      A_STAT:  bus_rdata = {5'b0, ovf, half, empty};
      default: bus_rdata = 8'h00;
    endcase
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);
  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flush_wr) |=> ovf);
  assert_drop_sets_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !flush_wr) |=> (ovf && count == CNT_FULL));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr |=> (empty && !ovf && !irq));
  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !irq);
  assert_disabled_no_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flush_wr) |=> count <= $past(count));
  assert_empty_read_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd && empty && !flush_wr) |=> $stable(rd_ptr));
  assert_push_pop_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && do_pop && !flush_wr) |=> count == $past(count));
endmodule

// File: tb/conv_fifo_test.sv
module conv_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [15:0] push_data = '0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [15:0] VEC [6] = '{16'h0000, 16'hFFF5, 16'h1237, 16'hA5AF, 16'h8001, 16'h7FFE};

  always #5 clk = ~clk;

  conv_fifo uut (.clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic pop(output logic [15:0] w);
    logic [7:0] lo, hi;
    rd(3'd2, lo); rd(3'd3, hi); w = {hi, lo};
  endtask

  task automatic push_n(int n, logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); push_valid = 1'b1; push_data = base + 16'(i);
    end
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic status(output logic [7:0] s);
    rd(3'd4, s);
  endtask

  task automatic settle();
    repeat (2) @(posedge clk); #1;
  endtask

  initial begin
    logic [7:0] s;
    logic [15:0] w;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    status(s); chk("R1 status", s, 8'h01);
    chk("R1 irq", irq, 1'b0);
    wr(3'd0, 8'h01);

    foreach (VEC[i]) push_n(1, VEC[i]);
    foreach (VEC[i]) begin pop(w); chk("R2 order/bytes", w, VEC[i]); end
    status(s); chk("R3 empty after drain", s, 8'h01);

    wr(3'd0, 8'h00); push_n(3, 16'h0100);
    status(s); chk("R8 disabled push ignored", s, 8'h01);
    wr(3'd0, 8'h01); push_n(2, 16'h0A10);
    wr(3'd0, 8'h00); push_n(1, 16'h0C30);
    pop(w); chk("R8 kept entry A", w, 16'h0A10);
    pop(w); chk("R8 kept entry B", w, 16'h0A11);
    status(s); chk("R8 dropped entry C", s, 8'h01);

    rd(3'd2, s); chk("R9 empty low read", s, 8'h11);
    wr(3'd0, 8'h01); push_n(1, 16'h3D4E);
    pop(w); chk("R9 pointers unmoved", w, 16'h3D4E);

    push_n(1, 16'h5E01);
    rd(3'd2, s); chk("R11 low of E", s, 8'h01);
    @(negedge clk); bus_addr = 3'd3; bus_rd = 1'b1; push_valid = 1'b1; push_data = 16'h6F02;
    #1 chk("R11 high of E", bus_rdata, 8'h5E);
    @(posedge clk); #1 bus_rd = 1'b0; push_valid = 1'b0;
    status(s); chk("R11 one entry left", s, 8'h00);
    pop(w); chk("R11 entry F", w, 16'h6F02);
    status(s); chk("R11 empty after F", s, 8'h01);

    wr(3'd4, 8'h00);
    push_n(511, 16'h0000); settle();
    chk("R4 irq low at 511", irq, 1'b0);
    status(s); chk("R3 half clear at 511", s, 8'h00);
    push_n(1, 16'h01FF); settle();
    chk("R4 irq at 512", irq, 1'b1);
    status(s); chk("R3 half set at 512", s, 8'h02);
    wr(3'd1, 8'h00); #1 chk("R5 irq cleared", irq, 1'b0);
    push_n(1, 16'h0200); settle();
    chk("R5 no re-fire at 513", irq, 1'b0);
    pop(w); chk("R2 head after burst", w, 16'h0000);
    pop(w); settle();
    chk("R5 low at 511", irq, 1'b0);
    push_n(1, 16'h0201); settle();
    chk("R5 re-fire at 512", irq, 1'b1);

    push_n(512, 16'h1000); settle();
    status(s); chk("R6 full no overflow", s, 8'h02);
    push_n(1, 16'hEEEE); settle();
    status(s); chk("R6 overflow set", s, 8'h06);
    pop(w); chk("R6 head intact", w, 16'h0002);
    status(s); chk("R6 overflow sticky", s, 8'h06);

    wr(3'd1, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'h00);
    status(s); chk("R7 R10 flushed", s, 8'h01);
    chk("R10 irq low", irq, 1'b0);
    push_n(4, 16'h4444); settle();
    status(s); chk("R10 push ignored after shutdown", s, 8'h01);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); checks++; fails++; $display("FAIL watchdog: actual hung expected done"); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule